// File: doc/BRIEF.md
# Write Buffer with Read-Miss Bypass

This block sits between a write-through data cache and the next level of memory. Every store the CPU makes is posted into a small queue, and the CPU does not wait while an entry is free. The queue then retires the stores to memory one at a time, oldest first, over a request/ready handshake.

A read miss does not have to wait behind the queued stores. In the default mode, the miss address is compared against every occupied entry. If no entry holds that address, the read takes the memory port ahead of any store that has not yet been presented. If one or more entries hold it, the newest of those supplies the data in the same cycle and memory is not touched. A parameter selects a simpler mode instead, in which a read miss is held back until the queue has fully drained.

The memory port completes a transaction on a rising edge where `mem_req` and `mem_ready` are both high. For a read, `mem_rdata` is valid in that cycle. The read requester holds `rd_valid` and `rd_addr` until it sees `rd_done`.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset, `wr_ready` is 1, and `mem_req` and `rd_done` are 0.
- R2: Up to 4 writes are accepted while memory is stalled. `wr_ready` is 0 while 4 entries are occupied and none retires in that cycle.
- R3: While all 4 entries are occupied, a write offered in the same cycle that the oldest entry is accepted by memory is itself accepted (`wr_ready` is 1).
- R4: Queued writes reach memory in arrival order, one per accepted transaction, with `mem_we` = 1 and the entry's address and data.
- R5: Once a write request is shown to memory, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until `mem_ready` is seen.
- R6: In bypass mode, a read miss whose address matches no entry is presented to memory (`mem_we` = 0, `mem_addr` = `rd_addr`) before any queued write not yet presented. `rd_done` rises in the cycle `mem_ready` is high, with `rd_data` = `mem_rdata` and `rd_src_buf` = 0.
- R7: In bypass mode, a read miss that matches an entry completes in the cycle it is raised, with `rd_src_buf` = 1 and no memory read. This may happen in the same cycle that a write retires.
- R8: When several entries match, `rd_data` is the data of the most recently accepted matching write.
- R9: In wait mode (`BYPASS` = 0), a read is presented to memory only when the queue is empty. It is never served from the queue, so `rd_src_buf` = 0 even when an entry matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | CPU offers a write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_ready | output | 1 | Write is taken on this edge when wr_valid is high |
| rd_valid | input | 1 | Read miss pending, held until rd_done |
| rd_addr | input | AW | Read miss address |
| rd_done | output | 1 | Read miss completes on this edge |
| rd_data | output | DW | Read result, valid with rd_done |
| rd_src_buf | output | 1 | 1 when the result came from the queue |
| mem_req | output | 1 | Memory transaction requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Memory read data, valid with mem_ready on a read |

## Verification
Two pairs of functions can collide in one cycle, and the bench creates each pair on purpose.

The first pair is a CPU write and the retirement of the oldest entry. The bench stalls memory until the queue is full, then raises `mem_ready` in the same cycle that it offers a fifth write. It checks that the write is accepted and that all five writes later leave in order.

The second pair is a forwarded read hit and a write drain. The bench raises `mem_ready` while a matching read is pending. It checks that the forwarded data arrives in that cycle while the head write sits on the memory port, and that the memory log shows no read.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    SEL_IDLE  = 2'd0,
    SEL_WRITE = 2'd1,
    SEL_READ  = 2'd2
  } mem_sel_e;

  // Occupancy after one cycle of pushes and pops.
  function automatic int unsigned count_after(int unsigned cur, logic push, logic pop);
    return cur + int'(push) - int'(pop);
  endfunction

endpackage

// File: rtl/wbuf_queue.sv
module wbuf_queue #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          ent_vld  [DEPTH],
  output logic [AW-1:0] ent_addr [DEPTH],
  output logic [DW-1:0] ent_data [DEPTH]
);

  // Slot 0 holds the oldest entry; a pop shifts everything down by one.
  logic [AW-1:0] a_q [DEPTH];
  logic [DW-1:0] d_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] wr_pos;

  assign wr_pos = cnt_q - CW'(pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (pop) begin
          a_q[i] <= a_q[i+1];
          d_q[i] <= d_q[i+1];
        end
      end
      if (push) begin
        a_q[wr_pos[IW-1:0]] <= push_addr;
        d_q[wr_pos[IW-1:0]] <= push_data;
      end
      cnt_q <= CW'(wbuf_pkg::count_after(int'(cnt_q), push, pop));
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign ent_vld[g]  = (CW'(g) < cnt_q);
    assign ent_addr[g] = a_q[g];
    assign ent_data[g] = d_q[g];
  end

  assign count     = cnt_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_addr = a_q[0];
  assign head_data = d_q[0];

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  p_swap_keeps_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          ent_vld  [DEPTH],
  input  logic [AW-1:0] ent_addr [DEPTH],
  input  logic [DW-1:0] ent_data [DEPTH],
  input  logic [AW-1:0] look_addr,
  output logic          hit,
  output logic [DW-1:0] hit_data
);

  // Higher slot = younger entry, so a later match overrides an earlier one.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_vld[i] && (ent_addr[i] == look_addr)) begin
        hit      = 1'b1;
        hit_data = ent_data[i];
      end
    end
  end

endmodule

// File: rtl/wbuf_arb.sv
module wbuf_arb #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter bit BYPASS = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          fwd_hit,
  input  logic          q_empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          pop,
  output logic          rd_issue,
  output logic          rd_fwd
);
  import wbuf_pkg::*;

  mem_sel_e sel;
  logic     hold_q;

  assign rd_fwd = BYPASS && rd_valid && fwd_hit;

  // A write already shown to memory keeps the port; otherwise a read
  // miss goes first (bypass) or only once the queue is empty (wait).
  always_comb begin
    sel = SEL_IDLE;
    if (hold_q)
      sel = SEL_WRITE;
    else if (rd_valid && !rd_fwd && (BYPASS || q_empty))
      sel = SEL_READ;
    else if (!q_empty)
      sel = SEL_WRITE;
  end

  assign mem_req   = (sel != SEL_IDLE);
  assign mem_we    = (sel == SEL_WRITE);
  assign mem_addr  = (sel == SEL_READ) ? rd_addr : head_addr;
  assign mem_wdata = head_data;
  assign pop       = (sel == SEL_WRITE) && mem_ready;
  assign rd_issue  = (sel == SEL_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= (sel == SEL_WRITE) && !mem_ready;
  end

  p_req_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ready) |=>
      (mem_req && mem_we && $stable(mem_addr) && $stable(mem_wdata)));

endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int DEPTH  = 4,
  parameter bit BYPASS = 1'b1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic          rd_src_buf,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);

  logic          push, pop, q_full, q_empty, hit, rd_issue, rd_fwd;
  logic [CW-1:0] q_cnt;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, hit_data;
  logic          ent_vld  [DEPTH];
  logic [AW-1:0] ent_addr [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];

  // A slot freed on this edge can take the incoming write.
  assign wr_ready = !q_full || pop;
  assign push     = wr_valid && wr_ready;

  wbuf_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(wr_addr),
    .push_data(wr_data), .pop(pop), .count(q_cnt), .full(q_full),
    .empty(q_empty), .head_addr(head_addr), .head_data(head_data),
    .ent_vld(ent_vld), .ent_addr(ent_addr), .ent_data(ent_data)
  );

  wbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
    .ent_vld(ent_vld), .ent_addr(ent_addr), .ent_data(ent_data),
    .look_addr(rd_addr), .hit(hit), .hit_data(hit_data)
  );

  wbuf_arb #(.AW(AW), .DW(DW), .BYPASS(BYPASS)) u_arb (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .fwd_hit(hit), .q_empty(q_empty), .head_addr(head_addr),
    .head_data(head_data), .mem_ready(mem_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pop(pop), .rd_issue(rd_issue), .rd_fwd(rd_fwd)
  );

  assign rd_done    = rd_fwd || (rd_issue && mem_ready);
  assign rd_data    = rd_fwd ? hit_data : mem_rdata;
  assign rd_src_buf = rd_fwd;

  p_done_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> rd_valid);

  p_fwd_no_memread_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_src_buf |-> !(mem_req && !mem_we));

  if (!BYPASS) begin : g_wait_chk
    p_wait_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (q_cnt == '0));
  end

endmodule

// File: tb/wbuf_bypass_test.sv
`timescale 1ns/1ps
module wbuf_bypass_test;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, rd_valid = 1'b0;
  logic [31:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic        wr_ready, rd_done, rd_src_buf, mem_req, mem_we;
  logic [31:0] rd_data, mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b0;
  logic        wr_ready_w, rd_done_w, rd_src_buf_w, mem_req_w, mem_we_w;
  logic [31:0] rd_data_w, mem_addr_w, mem_wdata_w, mem_rdata_w;
  logic        mem_ready_w = 1'b1;

  int n_chk = 0, n_bad = 0;
  logic        log_we [64], log2_we [64];
  logic [31:0] log_addr [64], log_data [64], log2_addr [64], log2_data [64];
  int log_n = 0, log2_n = 0;

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [31:0] mem_model(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  assign mem_rdata   = mem_model(mem_addr);
  assign mem_rdata_w = mem_model(mem_addr_w);

  wbuf_bypass #(.BYPASS(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
    .rd_src_buf(rd_src_buf), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata));

  wbuf_bypass #(.BYPASS(1'b0)) uut_wait (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready_w), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_done(rd_done_w), .rd_data(rd_data_w),
    .rd_src_buf(rd_src_buf_w), .mem_req(mem_req_w), .mem_we(mem_we_w),
    .mem_addr(mem_addr_w), .mem_wdata(mem_wdata_w), .mem_ready(mem_ready_w),
    .mem_rdata(mem_rdata_w));

  // Record each transaction that the coming edge will complete.
  always @(negedge clk) begin
    #2;
    if (rst_n && mem_req && mem_ready && log_n < 64) begin
      log_we[log_n]   = mem_we;
      log_addr[log_n] = mem_addr;
      log_data[log_n] = mem_we ? mem_wdata : mem_rdata;
      log_n++;
    end
    if (rst_n && mem_req_w && mem_ready_w && log2_n < 64) begin
      log2_we[log2_n]   = mem_we_w;
      log2_addr[log2_n] = mem_addr_w;
      log2_data[log2_n] = mem_we_w ? mem_wdata_w : mem_rdata_w;
      log2_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_log(input string req, input int idx, input logic we,
                         input logic [31:0] a, input logic [31:0] d);
    chk({req, " log we"},   32'(log_we[idx]), 32'(we));
    chk({req, " log addr"}, log_addr[idx], a);
    chk({req, " log data"}, log_data[idx], d);
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 wr_ready", 32'(wr_ready), 32'd1);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 rd_done", 32'(rd_done), 32'd0);
    chk("R1 wait mem_req", 32'(mem_req_w), 32'd0);
    @(negedge clk);
  endtask

  task automatic t_drain_order;
    log_n = 0; mem_ready = 1'b0;
    for (int i = 0; i < 4; i++) push(32'h100 + 32'(4*i), 32'hD000 + 32'(i));
    #1;
    chk("R2 full wr_ready", 32'(wr_ready), 32'd0);
    chk("R4 head we", 32'(mem_req && mem_we), 32'd1);
    chk("R4 head addr", mem_addr, 32'h100);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R5 held req", 32'(mem_req && mem_we), 32'd1);
      chk("R5 held addr", mem_addr, 32'h100);
      chk("R5 held data", mem_wdata, 32'hD000);
    end
    @(negedge clk); mem_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk("R4 write count", 32'(log_n), 32'd4);
    for (int i = 0; i < 4; i++)
      chk_log("R4 order", i, 1'b1, 32'h100 + 32'(4*i), 32'hD000 + 32'(i));
  endtask

  task automatic t_full_retire;
    log_n = 0; mem_ready = 1'b0;
    for (int i = 0; i < 4; i++) push(32'h180 + 32'(4*i), 32'hE000 + 32'(i));
    wr_valid = 1'b1; wr_addr = 32'h190; wr_data = 32'hE004; mem_ready = 1'b1;
    #1;
    chk("R3 accept on retire", 32'(wr_ready), 32'd1);
    @(negedge clk);
    wr_valid = 1'b0; mem_ready = 1'b0;
    #1;
    chk("R2 still full", 32'(wr_ready), 32'd0);
    @(negedge clk); mem_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk("R3 write count", 32'(log_n), 32'd5);
    for (int i = 0; i < 5; i++)
      chk_log("R3 order", i, 1'b1, 32'h180 + 32'(4*i), 32'hE000 + 32'(i));
  endtask

  task automatic t_bypass;
    logic [31:0] got_d;
    logic        got_s;
    log_n = 0; mem_ready = 1'b0;
    push(32'h200, 32'hA1); push(32'h204, 32'hA2);
    rd_valid = 1'b1; rd_addr = 32'h300; mem_ready = 1'b1;
    #1;
    while (!rd_done) begin @(negedge clk); #1; end
    got_d = rd_data; got_s = rd_src_buf;
    @(negedge clk); rd_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 read data", got_d, mem_model(32'h300));
    chk("R6 source flag", 32'(got_s), 32'd0);
    chk("R6 txn count", 32'(log_n), 32'd3);
    chk_log("R6 held write first", 0, 1'b1, 32'h200, 32'hA1);
    chk_log("R6 read ahead", 1, 1'b0, 32'h300, mem_model(32'h300));
    chk_log("R6 later write", 2, 1'b1, 32'h204, 32'hA2);
  endtask

  task automatic t_forward;
    log_n = 0; mem_ready = 1'b0;
    push(32'h400, 32'h11); push(32'h404, 32'h22); push(32'h400, 32'h33);
    rd_valid = 1'b1; rd_addr = 32'h400;
    #1;
    chk("R7 hit done", 32'(rd_done), 32'd1);
    chk("R7 hit source", 32'(rd_src_buf), 32'd1);
    chk("R8 youngest data", rd_data, 32'h33);
    chk("R7 no mem read", 32'(mem_req && !mem_we), 32'd0);
    @(negedge clk);
    rd_addr = 32'h404; mem_ready = 1'b1;
    #1;
    chk("R7 hit with drain", 32'(rd_done && rd_src_buf), 32'd1);
    chk("R7 hit data", rd_data, 32'h22);
    chk("R7 drain same cycle", 32'(mem_req && mem_we), 32'd1);
    @(negedge clk); rd_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 only writes", 32'(log_n), 32'd3);
    chk_log("R7 order", 0, 1'b1, 32'h400, 32'h11);
    chk_log("R7 order", 1, 1'b1, 32'h404, 32'h22);
    chk_log("R7 order", 2, 1'b1, 32'h400, 32'h33);
  endtask

  task automatic t_wait;
    logic [31:0] got_d;
    logic        got_s;
    log_n = 0; log2_n = 0; mem_ready = 1'b0; mem_ready_w = 1'b0;
    push(32'h500, 32'hB1); push(32'h504, 32'hB2);
    rd_valid = 1'b1; rd_addr = 32'h504;
    #1;
    chk("R9 write holds port", 32'(mem_req_w && mem_we_w), 32'd1);
    chk("R9 no forward", 32'(rd_done_w), 32'd0);
    @(negedge clk); #1;
    chk("R9 still waiting", 32'(mem_req_w && mem_we_w), 32'd1);
    @(negedge clk); mem_ready_w = 1'b1;
    #1;
    while (!rd_done_w) begin @(negedge clk); #1; end
    got_d = rd_data_w; got_s = rd_src_buf_w;
    @(negedge clk); rd_valid = 1'b0; mem_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 read data", got_d, mem_model(32'h504));
    chk("R9 source flag", 32'(got_s), 32'd0);
    chk("R9 txn count", 32'(log2_n), 32'd3);
    chk("R9 first write", log2_addr[0], 32'h500);
    chk("R9 second write", log2_addr[1], 32'h504);
    chk("R9 read last", 32'(log2_we[2]), 32'd0);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_drain_order();
    t_full_retire();
    t_bypass();
    t_forward();
    t_wait();
    report();
    $finish;
  end

endmodule